// File: doc/BRIEF.md
# Management-Mode Entry and Exit Controller

This block keeps track of whether a processor core is running in its privileged management mode, and it owns the core's program counter. A management interrupt request moves the core into the mode. On that transition the program counter is loaded with an entry vector, which is the value of a programmable base register plus a fixed offset of 0x8000. The mode cannot be re-entered: a request that arrives while the core is already in the mode is held as a single pending request. That pending request is taken once a resume strobe has brought the core back to the unprivileged mode.

Outside of entry, a next-instruction strobe loads the program counter with any supplied physical address, in either mode, with no limit on the target. Software sets the base register through a plain write port. The management region must be larger than 0x8000 bytes, so that the entry vector falls inside the region when the base points at its start. Meeting that condition is the job of the software that programs the base register. All outputs are registered, and an input sampled at a rising clock edge shows at the outputs just after that edge.

Top module: `mgmt_mode_ctrl`

## Requirements
- R1: While `rst` is high, and right after it falls, `in_mgmt` is 0, `irq_ack` is 0, `pc` equals parameter `PC_RST`, no request is pending, and the base register holds parameter `BASE_RST`.
- R2: A request (`mgmt_irq` high, or one pending) seen at an edge while `in_mgmt` is 0 is accepted at that edge. After the edge, `in_mgmt` is 1, `pc` is base + 0x8000, and `irq_ack` is 1 for exactly that one cycle.
- R3: `mgmt_irq` seen while `in_mgmt` is 1 gives no `irq_ack` and leaves `pc` and `in_mgmt` unchanged.
- R4: `resume_stb` seen while `in_mgmt` is 1 clears `in_mgmt` after the edge. A request pending at that time is accepted at the next edge, as in R2.
- R5: `resume_stb` seen while `in_mgmt` is 0 is ignored. `in_mgmt` stays 0, `pc` is unchanged, and no error is raised.
- R6: `jump_vld` without an accepted request loads `pc` with `jump_addr` after the edge, for any address.
- R7: When a request is accepted in the same cycle as `jump_vld`, the entry vector wins and `jump_addr` is discarded.
- R8: A base write (`base_we`) is applied at the edge. A request accepted at that same edge uses the old base value, and later requests use the new one.
- R9: The entry vector is computed modulo 2^`ADDR_W`, so a base near the top of the address space wraps around.
- R10: Any number of requests during one stay in the mode merge into one pending request, which produces exactly one later acceptance.
- R11: `jump_vld` while `in_mgmt` is 1 changes `pc` but does not leave the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_irq | input | 1 | Management interrupt request strobe |
| resume_stb | input | 1 | Resume instruction executed |
| jump_vld | input | 1 | Next-instruction event |
| jump_addr | input | ADDR_W | Target address of the next-instruction event |
| base_we | input | 1 | Base register write enable |
| base_wdata | input | ADDR_W | Base register write data |
| pc | output | ADDR_W | Program counter |
| in_mgmt | output | 1 | Core is in management mode |
| irq_ack | output | 1 | One-cycle pulse when a request is accepted |

## Verification
Three pairs of events can land in the same cycle. The first pair is request acceptance and a next-instruction jump, which compete for the program counter. The second is a resume and a new request in the same cycle while in the mode. The third is a base write and an acceptance, which must use the old base. Directed steps drive each pair on one clock edge. A reference model in the bench, written from the requirements, predicts `pc`, `in_mgmt` and `irq_ack` one edge later, and a scoreboard compares the prediction with the outputs. A long run of random strobes then mixes these collisions with pending requests and address wrap.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  // Operating mode of the core as tracked by the controller
  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_MGMT = 1'b1
  } mode_e;

  // Next-state decision of the program counter
  typedef enum logic [1:0] {
    PC_HOLD  = 2'd0,
    PC_ENTRY = 2'd1,
    PC_JUMP  = 2'd2
  } pc_sel_e;
endpackage

// File: rtl/mmc_base_reg.sv
module mmc_base_reg #(
  parameter int unsigned       ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_q
);
  // The new value is visible only from the cycle after the write
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= RST_VAL;
    end else if (we) begin
      base_q <= wdata;
    end
  end
endmodule

// File: rtl/mmc_mode_seq.sv
module mmc_mode_seq
  import mmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic resume,
  output logic accept,
  output logic in_mode,
  output logic ack_q
);
  mode_e mode_q, mode_d;
  logic  pend_q, pend_d;
  logic  want;

  assign want    = irq | pend_q;
  assign accept  = want && (mode_q == MODE_USER);
  assign in_mode = (mode_q == MODE_MGMT);

  always_comb begin
    mode_d = mode_q;
    pend_d = pend_q;
    if (accept) begin
      mode_d = MODE_MGMT;
      pend_d = 1'b0;
    end else if (mode_q == MODE_MGMT) begin
      // Requests arriving inside the mode merge into one pending flag
      if (irq) begin
        pend_d = 1'b1;
      end
      if (resume) begin
        mode_d = MODE_USER;
      end
    end
    // A resume outside the mode falls through with no effect
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_USER;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      ack_q  <= accept;
    end
  end
endmodule

// File: rtl/mmc_pc_reg.sv
module mmc_pc_reg
  import mmc_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] ENTRY_OFS = 'h8000,
  parameter logic [ADDR_W-1:0] PC_RST    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] base,
  input  logic              jump_vld,
  input  logic [ADDR_W-1:0] jump_addr,
  output logic [ADDR_W-1:0] pc_q
);
  pc_sel_e           sel;
  logic [ADDR_W-1:0] entry_vec;

  // Wraps modulo 2^ADDR_W by truncation
  assign entry_vec = base + ENTRY_OFS;

  // Entry outranks a jump in the same cycle
  always_comb begin
    if (accept) begin
      sel = PC_ENTRY;
    end else if (jump_vld) begin
      sel = PC_JUMP;
    end else begin
      sel = PC_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= PC_RST;
    end else begin
      unique case (sel)
        PC_ENTRY: pc_q <= entry_vec;
        PC_JUMP:  pc_q <= jump_addr;
        default:  pc_q <= pc_q;
      endcase
    end
  end
endmodule

// File: rtl/mgmt_mode_ctrl.sv
module mgmt_mode_ctrl #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] ENTRY_OFS = 'h8000,
  parameter logic [ADDR_W-1:0] BASE_RST  = 'h0003_0000,
  parameter logic [ADDR_W-1:0] PC_RST    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mgmt_irq,
  input  logic              resume_stb,
  input  logic              jump_vld,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic              in_mgmt,
  output logic              irq_ack
);
  logic [ADDR_W-1:0] base_q;
  logic              accept;

  mmc_base_reg #(
    .ADDR_W (ADDR_W),
    .RST_VAL(BASE_RST)
  ) u_base (
    .clk   (clk),
    .rst   (rst),
    .we    (base_we),
    .wdata (base_wdata),
    .base_q(base_q)
  );

  mmc_mode_seq u_mode (
    .clk    (clk),
    .rst    (rst),
    .irq    (mgmt_irq),
    .resume (resume_stb),
    .accept (accept),
    .in_mode(in_mgmt),
    .ack_q  (irq_ack)
  );

  mmc_pc_reg #(
    .ADDR_W   (ADDR_W),
    .ENTRY_OFS(ENTRY_OFS),
    .PC_RST   (PC_RST)
  ) u_pc (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .base     (base_q),
    .jump_vld (jump_vld),
    .jump_addr(jump_addr),
    .pc_q     (pc)
  );
endmodule

// File: rtl/mmc_checker.sv
module mmc_checker #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] ENTRY_OFS = 'h8000
) (
  input logic              clk,
  input logic              rst,
  input logic              resume_stb,
  input logic              jump_vld,
  input logic [ADDR_W-1:0] jump_addr,
  input logic [ADDR_W-1:0] base,
  input logic [ADDR_W-1:0] pc,
  input logic              in_mgmt,
  input logic              irq_ack
);
  // R2
  ack_in_mode_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> in_mgmt);

  // R2
  entry_pc_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (pc == ADDR_W'($past(base) + ENTRY_OFS)));

  // R3
  no_reentry_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !$past(in_mgmt));

  // R4
  exit_by_resume_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_mgmt) |-> $past(resume_stb));

  // R6
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    jump_vld |=> (irq_ack || pc == $past(jump_addr)));

  // R10
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);
endmodule

bind mgmt_mode_ctrl mmc_checker #(
  .ADDR_W   (ADDR_W),
  .ENTRY_OFS(ENTRY_OFS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .resume_stb(resume_stb),
  .jump_vld  (jump_vld),
  .jump_addr (jump_addr),
  .base      (base_q),
  .pc        (pc),
  .in_mgmt   (in_mgmt),
  .irq_ack   (irq_ack)
);

// File: tb/mgmt_mode_ctrl_tb.sv
module mgmt_mode_ctrl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 32;
  localparam logic [31:0] OFS        = 32'h0000_8000;
  localparam logic [31:0] BASE0      = 32'h0003_0000;
  localparam logic [31:0] PC0        = 32'h0000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mgmt_irq = 1'b0, resume_stb = 1'b0, jump_vld = 1'b0, base_we = 1'b0;
  logic [AW-1:0] jump_addr = '0, base_wdata = '0;
  logic [AW-1:0] pc;
  logic          in_mgmt, irq_ack;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [AW-1:0] pc;
    logic          mode;
    logic          ack;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  // Reference model state
  logic [AW-1:0] m_pc = PC0, m_base = BASE0;
  logic          m_mode = 1'b0, m_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_mode_ctrl #(
    .ADDR_W   (AW),
    .ENTRY_OFS(OFS),
    .BASE_RST (BASE0),
    .PC_RST   (PC0)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .mgmt_irq  (mgmt_irq),
    .resume_stb(resume_stb),
    .jump_vld  (jump_vld),
    .jump_addr (jump_addr),
    .base_we   (base_we),
    .base_wdata(base_wdata),
    .pc        (pc),
    .in_mgmt   (in_mgmt),
    .irq_ack   (irq_ack)
  );

  task automatic cmp(input string tag, input logic [AW-1:0] a_pc, e_pc,
                     input logic a_m, e_m, a_k, e_k);
    checks++;
    if (a_pc !== e_pc || a_m !== e_m || a_k !== e_k) begin
      fails++;
      $display("FAIL %s: pc=%h in_mgmt=%b ack=%b expected pc=%h in_mgmt=%b ack=%b",
               tag, a_pc, a_m, a_k, e_pc, e_m, e_k);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the predicted outcome
  task automatic step(input logic irq, res, jv, input logic [AW-1:0] ja,
                      input logic bw, input logic [AW-1:0] bd, input string tag);
    logic acc;
    exp_t e;
    @(negedge clk);
    mgmt_irq = irq; resume_stb = res; jump_vld = jv; jump_addr = ja;
    base_we = bw; base_wdata = bd;
    acc = (irq || m_pend) && !m_mode;
    if (acc) begin
      m_pc = m_base + OFS;
      m_mode = 1'b1;
      m_pend = 1'b0;
    end else begin
      if (jv) m_pc = ja;
      if (m_mode && irq) m_pend = 1'b1;
      if (m_mode && res) m_mode = 1'b0;
    end
    if (bw) m_base = bd;
    e.pc = m_pc; e.mode = m_mode; e.ack = acc; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  // Monitor: compares after each edge, clear of the driver's negedge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.tag, pc, e.pc, in_mgmt, e.mode, irq_ack, e.ack);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at reset values
    cmp("R1 during reset", pc, PC0, in_mgmt, 1'b0, irq_ack, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 after reset", pc, PC0, in_mgmt, 1'b0, irq_ack, 1'b0);

    step(0, 0, 1, 32'h0000_1000, 0, '0, "R6 jump outside");
    step(0, 1, 0, '0, 0, '0, "R5 resume ignored");
    idle("R5 idle after stray resume");
    step(1, 0, 0, '0, 0, '0, "R2 entry default base R1");
    idle("R2 ack single pulse");
    step(1, 0, 0, '0, 0, '0, "R3 irq in mode");
    step(1, 0, 0, '0, 0, '0, "R10 second irq in mode");
    step(0, 0, 1, 32'h0003_8010, 0, '0, "R11 jump stays in mode");
    step(0, 1, 0, '0, 0, '0, "R4 resume exits");
    idle("R4 pending taken");
    idle("R10 no second acceptance");
    step(0, 1, 0, '0, 0, '0, "R4 resume");
    idle("R10 nothing pending");
    step(1, 0, 0, '0, 1, 32'h0010_0000, "R8 same-cycle write uses old base");
    step(0, 1, 0, '0, 0, '0, "R4 resume");
    step(1, 0, 0, '0, 0, '0, "R8 new base used");
    step(0, 1, 0, '0, 0, '0, "R4 resume");
    step(1, 0, 1, 32'h0000_2222, 0, '0, "R7 entry beats jump");
    step(1, 1, 0, '0, 1, 32'hFFFF_C000, "R4 resume with irq same cycle");
    idle("R9 wrapped entry vector");
    step(0, 1, 0, '0, 0, '0, "R4 resume");
    step(0, 1, 1, 32'hDEAD_BEE0, 0, '0, "R5 R6 resume outside with jump");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0] == 3'd0, r[5:3] == 3'd0, r[8:7] == 2'd0, $urandom,
           r[13:10] == 4'd0, $urandom, "R2 R4 R7 random mix");
    end
    idle("R2 drain");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule